// File: doc/BRIEF.md
# Drive DMA Stream Formatter with Error Pointers

This block sits between a drive port that carries 9-bit symbols (one data byte plus one error flag) and a byte-wide buffer memory reached through an arbiter. A 5-bit mode word, sampled on a start pulse, picks the direction of the transfer and its layout. In the memory-to-drive direction, each byte read from the buffer goes to the drive with a constant error flag taken from configuration. In the drive-to-memory direction, the flags can be dropped. They can also be gathered eight at a time into pointer bytes. A pointer byte is stored either in its own region or right after the eight data bytes it describes.

A write transfer can first place a 12-byte synthetic sync header at the start address. The header bytes are not counted in the transfer length. The block issues one byte request at a time, with a write-enable, an address and write data, and holds each request until the arbiter grants it. Read data returns later on a valid strobe. When the transfer ends, the block pulses a done output. The remaining-length output then reads zero, and the data address output points just past the last byte placed in the data region.

Top module: `drive_ptr_fmt`

## Requirements
- R1: While mode bit 0 is 0, a start pulse is ignored: no memory request, no drive handshake and no done pulse follow, and busy stays low.
- R2: Mode bit 0 = 1 with bit 1 = 0 reads `xfer_len` bytes from ascending addresses starting at `data_base`. Each byte goes to the drive with `drv_out_flag` equal to the `rd_flag_cfg` value sampled at start. Bits 2 to 4 are ignored, so no write and no header occur.
- R3: Mode bits 0,1 = 1,1 with bit 2 = 0 writes each accepted drive byte to the next ascending address from `data_base`. The error flags are dropped and no other byte is written.
- R4: In a write transfer with mode bit 4 = 1, the bytes 0x00, ten times 0xFF, then 0x00 are written to `data_base`..`data_base`+11 before the first drive byte. The drive data follows at `data_base`+12, and the header is not counted in `xfer_len`.
- R5: Mode bits 0,1,2,3 = 1,1,1,0 (separated layout) writes a pointer byte after every eighth data byte. Pointer bytes go to ascending addresses starting at `ptr_base`.
- R6: Mode bits 0,1,2,3 = 1,1,1,1 (mixed layout) writes each pointer byte at the data address that follows its eight data bytes. `ptr_base` is ignored.
- R7: Bit k of a pointer byte holds the error flag of the k-th data byte of its group of eight. Bit 0 holds the first byte's flag.
- R8: After the last data write, pointer write or drive delivery, `done` pulses for one cycle and `busy` falls. `len_left` then reads 0, and `data_addr` holds the address after the last byte written to the data region (for a read, after the last byte read).
- R9: A memory request keeps `mem_req` high, with `mem_we`, `mem_addr` and `mem_wdata` unchanged, until the cycle in which `mem_gnt` is high. A byte offered on the drive output stays unchanged until `drv_out_ready`.
- R10: A start pulse that arrives while a transfer is running is ignored. The running transfer completes unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Start pulse; samples the configuration inputs when idle |
| mode | input | 5 | Transfer mode word |
| xfer_len | input | LEN_W | Number of data bytes to move |
| data_base | input | ADDR_W | Start address of the data region |
| ptr_base | input | ADDR_W | Start address of the pointer region (separated layout) |
| rd_flag_cfg | input | 1 | Error flag sent with every byte on reads |
| drv_in_valid | input | 1 | Drive offers a byte |
| drv_in_data | input | DATA_W | Drive data byte |
| drv_in_flag | input | 1 | Drive error flag |
| drv_in_ready | output | 1 | Block accepts the drive byte this cycle |
| drv_out_valid | output | 1 | Block offers a byte to the drive |
| drv_out_data | output | DATA_W | Byte to the drive |
| drv_out_flag | output | 1 | Error flag to the drive |
| drv_out_ready | input | 1 | Drive takes the byte |
| mem_req | output | 1 | Memory request |
| mem_we | output | 1 | 1 = write, 0 = read |
| mem_addr | output | ADDR_W | Memory byte address |
| mem_wdata | output | DATA_W | Memory write data |
| mem_gnt | input | 1 | Arbiter grants the request |
| mem_rvalid | input | 1 | Read data valid |
| mem_rdata | input | DATA_W | Read data |
| busy | output | 1 | Transfer running |
| done | output | 1 | One-cycle completion pulse |
| len_left | output | LEN_W | Data bytes still to move |
| data_addr | output | ADDR_W | Current data address counter |

## Verification
The embedded assertions check four rules on every cycle. An ungranted request, and an unaccepted drive byte, hold steady. The block is silent while idle. A read transfer never writes. Done is raised only with a zero length count. Only the bench scenarios can show the contents and order of the writes, through an address-and-data scoreboard: the header bytes, the bit placement in pointer bytes, the choice between the pointer region and the contiguous layout, and the final counter values. The same holds for rejecting a start while disabled or busy.

// File: rtl/drive_fmt_pkg.sv
package drive_fmt_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_SYNC,
        ST_WR_IN,
        ST_WR_DATA,
        ST_WR_PTR,
        ST_RD_REQ,
        ST_RD_WAIT,
        ST_RD_OUT
    } fmt_state_e;

    typedef struct packed {
        logic enable;
        logic to_drive;
        logic ptr_en;
        logic mixed;
        logic sync;
    } fmt_mode_t;

endpackage

// File: rtl/drive_fmt_mode_dec.sv
module drive_fmt_mode_dec
    import drive_fmt_pkg::*;
(
    input  logic [4:0] mode_raw,
    output fmt_mode_t  mode_dec
);
    always_comb begin
        mode_dec.enable   = mode_raw[0];
        mode_dec.to_drive = mode_raw[0] & ~mode_raw[1];
        mode_dec.ptr_en   = mode_raw[0] &  mode_raw[1] & mode_raw[2];
        mode_dec.mixed    = mode_raw[0] &  mode_raw[1] & mode_raw[2] & mode_raw[3];
        mode_dec.sync     = mode_raw[0] &  mode_raw[1] & mode_raw[4];
    end
endmodule

// File: rtl/drive_fmt_sync_gen.sv
module drive_fmt_sync_gen #(
    parameter int DATA_W   = 8,
    parameter int SYNC_LEN = 12,
    localparam int SIDX_W  = $clog2(SYNC_LEN)
) (
    input  logic [SIDX_W-1:0] idx,
    output logic [DATA_W-1:0] sync_byte
);
    localparam logic [SIDX_W-1:0] LAST_IDX = SIDX_W'(SYNC_LEN - 1);

    always_comb begin
        if (idx == '0 || idx == LAST_IDX) begin
            sync_byte = '0;
        end else begin
            sync_byte = '1;
        end
    end
endmodule

// File: rtl/drive_fmt_ptr_pack.sv
module drive_fmt_ptr_pack #(
    parameter int GRP   = 8,
    localparam int CNT_W = $clog2(GRP)
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           clr,
    input  logic           push,
    input  logic           flag,
    output logic [GRP-1:0] ptr_byte,
    output logic           grp_last
);
    typedef struct packed {
        logic [GRP-1:0]   bits;
        logic [CNT_W-1:0] cnt;
    } pack_t;

    pack_t d, q;

    always_comb begin
        d = q;
        if (clr) begin
            d.cnt = '0;
        end else if (push) begin
            d.bits[q.cnt] = flag;
            d.cnt         = (q.cnt == CNT_W'(GRP - 1)) ? '0 : q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end

    assign ptr_byte = q.bits;
    assign grp_last = (q.cnt == CNT_W'(GRP - 1));

    // R7
    grp_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (push && !clr && grp_last) |=> (q.bits[GRP-1] == $past(flag)));
endmodule

// File: rtl/drive_ptr_fmt.sv
module drive_ptr_fmt
    import drive_fmt_pkg::*;
#(
    parameter int DATA_W   = 8,
    parameter int ADDR_W   = 16,
    parameter int LEN_W    = 12,
    parameter int SYNC_LEN = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [4:0]        mode,
    input  logic [LEN_W-1:0]  xfer_len,
    input  logic [ADDR_W-1:0] data_base,
    input  logic [ADDR_W-1:0] ptr_base,
    input  logic              rd_flag_cfg,
    input  logic              drv_in_valid,
    input  logic [DATA_W-1:0] drv_in_data,
    input  logic              drv_in_flag,
    output logic              drv_in_ready,
    output logic              drv_out_valid,
    output logic [DATA_W-1:0] drv_out_data,
    output logic              drv_out_flag,
    input  logic              drv_out_ready,
    output logic              mem_req,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_wdata,
    input  logic              mem_gnt,
    input  logic              mem_rvalid,
    input  logic [DATA_W-1:0] mem_rdata,
    output logic              busy,
    output logic              done,
    output logic [LEN_W-1:0]  len_left,
    output logic [ADDR_W-1:0] data_addr
);
    localparam int SIDX_W = $clog2(SYNC_LEN);
    localparam logic [SIDX_W-1:0] SIDX_LAST = SIDX_W'(SYNC_LEN - 1);
    localparam logic [LEN_W-1:0]  LEN_ONE   = LEN_W'(1);

    typedef struct packed {
        fmt_state_e        state;
        fmt_mode_t         md;
        logic [LEN_W-1:0]  len;
        logic [ADDR_W-1:0] daddr;
        logic [ADDR_W-1:0] paddr;
        logic [SIDX_W-1:0] sidx;
        logic [DATA_W-1:0] byte_v;
        logic              need_ptr;
        logic              rd_flag;
        logic              done;
    } ctl_t;

    ctl_t d, q;

    fmt_mode_t         md_in;
    logic [DATA_W-1:0] sync_byte;
    logic [DATA_W-1:0] ptr_byte;
    logic              grp_last;
    logic              pk_push;
    logic              pk_clr;

    drive_fmt_mode_dec u_mode_dec (
        .mode_raw (mode),
        .mode_dec (md_in)
    );

    drive_fmt_sync_gen #(
        .DATA_W   (DATA_W),
        .SYNC_LEN (SYNC_LEN)
    ) u_sync_gen (
        .idx       (q.sidx),
        .sync_byte (sync_byte)
    );

    drive_fmt_ptr_pack #(
        .GRP (DATA_W)
    ) u_ptr_pack (
        .clk      (clk),
        .rst_n    (rst_n),
        .clr      (pk_clr),
        .push     (pk_push),
        .flag     (drv_in_flag),
        .ptr_byte (ptr_byte),
        .grp_last (grp_last)
    );

    always_comb begin
        d       = q;
        d.done  = 1'b0;
        pk_push = 1'b0;
        pk_clr  = 1'b0;
        unique case (q.state)
            ST_IDLE: begin
                if (start && md_in.enable) begin
                    d.md      = md_in;
                    d.len     = xfer_len;
                    d.daddr   = data_base;
                    d.paddr   = ptr_base;
                    d.rd_flag = rd_flag_cfg;
                    d.sidx    = '0;
                    pk_clr    = 1'b1;
                    if (md_in.to_drive) begin
                        d.state = (xfer_len == '0) ? ST_IDLE : ST_RD_REQ;
                        d.done  = (xfer_len == '0);
                    end else if (md_in.sync) begin
                        d.state = ST_SYNC;
                    end else begin
                        d.state = (xfer_len == '0) ? ST_IDLE : ST_WR_IN;
                        d.done  = (xfer_len == '0);
                    end
                end
            end
            ST_SYNC: begin
                if (mem_gnt) begin
                    d.daddr = q.daddr + 1'b1;
                    d.sidx  = q.sidx + 1'b1;
                    if (q.sidx == SIDX_LAST) begin
                        d.state = (q.len == '0) ? ST_IDLE : ST_WR_IN;
                        d.done  = (q.len == '0);
                    end
                end
            end
            ST_WR_IN: begin
                if (drv_in_valid) begin
                    d.byte_v   = drv_in_data;
                    d.need_ptr = q.md.ptr_en && grp_last;
                    pk_push    = 1'b1;
                    d.state    = ST_WR_DATA;
                end
            end
            ST_WR_DATA: begin
                if (mem_gnt) begin
                    d.daddr = q.daddr + 1'b1;
                    d.len   = q.len - 1'b1;
                    if (q.need_ptr) begin
                        d.state = ST_WR_PTR;
                    end else if (q.len == LEN_ONE) begin
                        d.state = ST_IDLE;
                        d.done  = 1'b1;
                    end else begin
                        d.state = ST_WR_IN;
                    end
                end
            end
            ST_WR_PTR: begin
                if (mem_gnt) begin
                    if (q.md.mixed) begin
                        d.daddr = q.daddr + 1'b1;
                    end else begin
                        d.paddr = q.paddr + 1'b1;
                    end
                    d.need_ptr = 1'b0;
                    d.state    = (q.len == '0) ? ST_IDLE : ST_WR_IN;
                    d.done     = (q.len == '0);
                end
            end
            ST_RD_REQ: begin
                if (mem_gnt) begin
                    d.state = ST_RD_WAIT;
                end
            end
            ST_RD_WAIT: begin
                if (mem_rvalid) begin
                    d.byte_v = mem_rdata;
                    d.state  = ST_RD_OUT;
                end
            end
            ST_RD_OUT: begin
                if (drv_out_ready) begin
                    d.daddr = q.daddr + 1'b1;
                    d.len   = q.len - 1'b1;
                    if (q.len == LEN_ONE) begin
                        d.state = ST_IDLE;
                        d.done  = 1'b1;
                    end else begin
                        d.state = ST_RD_REQ;
                    end
                end
            end
            default: d.state = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q       <= '0;
            q.state <= ST_IDLE;
        end else begin
            q <= d;
        end
    end

    always_comb begin
        mem_req = (q.state == ST_SYNC) || (q.state == ST_WR_DATA) ||
                  (q.state == ST_WR_PTR) || (q.state == ST_RD_REQ);
        mem_we  = (q.state != ST_RD_REQ);
        if (q.state == ST_WR_PTR && !q.md.mixed) begin
            mem_addr = q.paddr;
        end else begin
            mem_addr = q.daddr;
        end
        if (q.state == ST_SYNC) begin
            mem_wdata = sync_byte;
        end else if (q.state == ST_WR_PTR) begin
            mem_wdata = ptr_byte;
        end else begin
            mem_wdata = q.byte_v;
        end
    end

    assign drv_in_ready  = (q.state == ST_WR_IN);
    assign drv_out_valid = (q.state == ST_RD_OUT);
    assign drv_out_data  = q.byte_v;
    assign drv_out_flag  = q.rd_flag;
    assign busy          = (q.state != ST_IDLE);
    assign done          = q.done;
    assign len_left      = q.len;
    assign data_addr     = q.daddr;

    // R9
    req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_gnt) |=> (mem_req && $stable(mem_we) &&
                                   $stable(mem_addr) && $stable(mem_wdata)));

    // R9
    out_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (drv_out_valid && !drv_out_ready) |=> (drv_out_valid && $stable(drv_out_data)));

    // R1
    idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (!mem_req && !drv_in_ready && !drv_out_valid));

    // R2
    rd_no_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && q.md.to_drive) |-> !(mem_req && mem_we));

    // R8
    done_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (len_left == '0 && !busy));
endmodule

// File: tb/drive_ptr_fmt_bench.sv
module drive_ptr_fmt_bench;
    localparam int DATA_W = 8;
    localparam int ADDR_W = 16;
    localparam int LEN_W  = 12;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              start = 1'b0;
    logic [4:0]        mode = '0;
    logic [LEN_W-1:0]  xfer_len = '0;
    logic [ADDR_W-1:0] data_base = '0;
    logic [ADDR_W-1:0] ptr_base = '0;
    logic              rd_flag_cfg = 1'b0;
    logic              drv_in_valid = 1'b0;
    logic [DATA_W-1:0] drv_in_data = '0;
    logic              drv_in_flag = 1'b0;
    logic              drv_in_ready;
    logic              drv_out_valid;
    logic [DATA_W-1:0] drv_out_data;
    logic              drv_out_flag;
    logic              drv_out_ready = 1'b0;
    logic              mem_req;
    logic              mem_we;
    logic [ADDR_W-1:0] mem_addr;
    logic [DATA_W-1:0] mem_wdata;
    logic              mem_gnt = 1'b0;
    logic              mem_rvalid = 1'b0;
    logic [DATA_W-1:0] mem_rdata = '0;
    logic              busy;
    logic              done;
    logic [LEN_W-1:0]  len_left;
    logic [ADDR_W-1:0] data_addr;

    drive_ptr_fmt u_drive_ptr_fmt (.*);

    always #2 clk = ~clk;

    typedef struct {
        logic              we;
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] data;
        string             tag;
    } mem_item_t;

    typedef struct {
        logic [DATA_W-1:0] data;
        logic              flag;
    } out_item_t;

    mem_item_t exp_mem[$];
    out_item_t exp_out[$];
    int errors = 0;
    int checks = 0;
    int done_cnt = 0;
    int gcnt = 0;
    logic rd_pend = 1'b0;
    logic [ADDR_W-1:0] rd_addr = '0;

    function automatic logic [DATA_W-1:0] mdl(input logic [ADDR_W-1:0] a);
        return (a[7:0] * 8'd3) ^ 8'h5A;
    endfunction

    function automatic logic [DATA_W-1:0] bdat(input int i, input int seed);
        return DATA_W'(seed + i * 13);
    endfunction

    function automatic logic bflg(input int i, input int seed);
        return ((i * 5 + seed) >> 1) & 1;
    endfunction

    task automatic check(input bit ok, input string tag, input string what,
                         input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: %s actual=%0h expected=%0h", tag, what, act, exp);
        end
    endtask

    // Monitor, arbiter and memory model
    always @(negedge clk) begin
        mem_rvalid = 1'b0;
        if (rd_pend) begin
            mem_rvalid = 1'b1;
            mem_rdata  = mdl(rd_addr);
            rd_pend    = 1'b0;
        end
        gcnt++;
        mem_gnt = mem_req && (gcnt % 3 != 0);
        if (rst_n && mem_req && mem_gnt) begin
            if (exp_mem.size() == 0) begin
                check(1'b0, "R1 R10", "unexpected request addr", mem_addr, 0);
            end else begin
                mem_item_t e;
                e = exp_mem.pop_front();
                check(mem_we == e.we, e.tag, "we", mem_we, e.we);
                check(mem_addr == e.addr, e.tag, "addr", mem_addr, e.addr);
                if (e.we) check(mem_wdata == e.data, e.tag, "wdata", mem_wdata, e.data);
            end
            if (!mem_we) begin
                rd_pend = 1'b1;
                rd_addr = mem_addr;
            end
        end
        drv_out_ready = (gcnt % 4 != 2);
        if (rst_n && drv_out_valid && drv_out_ready) begin
            if (exp_out.size() == 0) begin
                check(1'b0, "R2", "unexpected drive byte", drv_out_data, 0);
            end else begin
                out_item_t o;
                o = exp_out.pop_front();
                check(drv_out_data == o.data, "R2", "drive data", drv_out_data, o.data);
                check(drv_out_flag == o.flag, "R2", "drive flag", drv_out_flag, o.flag);
            end
        end
        if (rst_n && done) done_cnt++;
    end

    task automatic pulse_start(input logic [4:0] m, input int len,
                               input int base, input int pbase, input logic rf);
        mode        = m;
        xfer_len    = LEN_W'(len);
        data_base   = ADDR_W'(base);
        ptr_base    = ADDR_W'(pbase);
        rd_flag_cfg = rf;
        start       = 1'b1;
        @(negedge clk);
        start       = 1'b0;
    endtask

    task automatic wait_finish(input int d0, input int exp_end, input string tag);
        int n = 0;
        while (done_cnt == d0 && n < 3000) begin
            @(negedge clk);
            n++;
        end
        // R8: completion state
        check(done_cnt == d0 + 1, "R8", "done pulses", done_cnt - d0, 1);
        check(len_left == 0, "R8", "len_left", len_left, 0);
        check(busy == 1'b0, "R8", "busy", busy, 0);
        check(data_addr == ADDR_W'(exp_end), "R8", "data_addr", data_addr, exp_end);
        check(exp_mem.size() == 0, tag, "missing memory ops", exp_mem.size(), 0);
        check(exp_out.size() == 0, tag, "missing drive bytes", exp_out.size(), 0);
    endtask

    task automatic run_write(input logic [4:0] m, input int len, input int base,
                             input int pbase, input int seed, input string tag);
        int a = base;
        int pa = pbase;
        logic [7:0] pb = '0;
        int d0 = done_cnt;
        bit ptr = m[2];
        bit mixed = m[2] && m[3];
        if (m[4]) begin
            for (int k = 0; k < 12; k++) begin
                exp_mem.push_back('{1'b1, ADDR_W'(a),
                                   (k == 0 || k == 11) ? 8'h00 : 8'hFF, "R4"});
                a++;
            end
        end
        for (int i = 0; i < len; i++) begin
            exp_mem.push_back('{1'b1, ADDR_W'(a), bdat(i, seed), tag});
            a++;
            pb[i % 8] = bflg(i, seed);
            if (ptr && (i % 8 == 7)) begin
                if (mixed) begin
                    exp_mem.push_back('{1'b1, ADDR_W'(a), pb, "R6 R7"});
                    a++;
                end else begin
                    exp_mem.push_back('{1'b1, ADDR_W'(pa), pb, "R5 R7"});
                    pa++;
                end
            end
        end
        pulse_start(m, len, base, pbase, 1'b0);
        for (int i = 0; i < len; i++) begin
            drv_in_valid = 1'b1;
            drv_in_data  = bdat(i, seed);
            drv_in_flag  = bflg(i, seed);
            while (!drv_in_ready) @(negedge clk);
            @(negedge clk);
            drv_in_valid = 1'b0;
            if (i % 3 == 2) @(negedge clk);
        end
        wait_finish(d0, a, tag);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog: run hung actual=1 expected=0");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        int d0;
        repeat (3) @(negedge clk);
        // Reset state (R1, R8)
        check(busy == 1'b0 && mem_req == 1'b0, "R1", "reset busy/req", {busy, mem_req}, 0);
        check(done == 1'b0 && len_left == 0, "R8", "reset done/len", {done, len_left}, 0);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: disabled mode ignores start
        d0 = done_cnt;
        pulse_start(5'b11110, 4, 'h0600, 'h0A00, 1'b1);
        repeat (30) @(negedge clk);
        check(busy == 1'b0, "R1", "busy after disabled start", busy, 0);
        check(done_cnt == d0, "R1", "done after disabled start", done_cnt - d0, 0);
        check(drv_in_ready == 1'b0, "R1", "drive ready", drv_in_ready, 0);

        // R2: read to drive, bits 2..4 set but ignored; R10: start while busy
        d0 = done_cnt;
        for (int i = 0; i < 5; i++) begin
            exp_mem.push_back('{1'b0, ADDR_W'('h0100 + i), 8'h00, "R2"});
            exp_out.push_back('{mdl(ADDR_W'('h0100 + i)), 1'b1});
        end
        pulse_start(5'b11101, 5, 'h0100, 'h0A00, 1'b1);
        repeat (6) @(negedge clk);
        check(busy == 1'b1, "R10", "busy mid transfer", busy, 1);
        pulse_start(5'b00011, 3, 'h0777, 'h0B00, 1'b0);
        rd_flag_cfg = 1'b0;
        wait_finish(d0, 'h0105, "R2 R10");

        // R3: data only, flags dropped
        run_write(5'b00011, 6, 'h0200, 'h0C00, 7, "R3");
        // R4: sync header then data only
        run_write(5'b10011, 3, 'h0300, 'h0C00, 21, "R4");
        // R5: separated pointer region
        run_write(5'b00111, 16, 'h0400, 'h0800, 3, "R5");
        // R6: mixed layout with sync header, ptr_base ignored
        run_write(5'b11111, 16, 'h0500, 'h0900, 40, "R6");

        repeat (5) @(negedge clk);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule